// File: doc/BRIEF.md
# Microcontroller Interrupt Status Unit

This unit collects four interrupt events from an embedded microcontroller core (halt, two software-raised events and an external error) into a sticky status vector. Software reads and manipulates that vector through a 32-bit word-addressed register bus. A single host interrupt line is raised when a pending source is enabled in two separate gates: a mask register and a destination register. Both gates can be written directly or through bit-set and bit-clear aliases, so software can change one source without a read-modify-write.

External errors also load a dedicated log register. It holds a valid flag and a code captured from the core. The valid flag is independent of the status bit and is cleared on its own by writing the log word back with the flag bit at zero.

The host line is a flop. A register write or event taken at one clock edge is reflected on the line from that same edge, so the line is visible in the cycle after the write.

Top module: `irq_agg_unit`

## Requirements
- R1: Status bit positions are halt = bit 0, software event 0 = bit 1, software event 1 = bit 2, external error = bit 3. A high event input sets its bit, and status bits 31..4 read as zero.
- R2: A write to word 2 (clear alias) clears every status bit written as one and leaves the bits written as zero unchanged.
- R3: A write to word 1 (set alias) sets every status bit written as one. Word 0 reads the status, and writes to word 0 are ignored.
- R4: Status bits are sticky and stay set after their event input drops. An event in the same cycle as a clear of its bit leaves the bit set.
- R5: `host_irq` equals the OR over the four bits of (status AND mask AND destination). It is registered and changes in the cycle after the write or event that alters it.
- R6: Word 3 reads and writes the mask. A write to word 4 sets the mask bits written as one, and a write to word 5 clears them. Words 4 and 5 read back the mask.
- R7: Word 6 reads and writes the destination. A write to word 7 sets the destination bits written as one, and a write to word 8 clears them. Words 7 and 8 read back the destination.
- R8: Word 9 is the error log: bit 31 is the valid flag and bits 7..0 hold the error code. An external-error event sets valid and captures `xerr_code`. A write with bit 31 at zero clears valid, a write with bit 31 at one leaves it unchanged, and writes never alter the code.
- R9: After reset the status, mask, destination and valid flag are zero, and `host_irq` is low.
- R10: Words 10 to 15 read as zero, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_wr | input | 1 | Write strobe for the addressed word |
| bus_addr | input | 4 | Word address |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for `bus_addr`, combinational from registered state |
| evt_halt | input | 1 | Halt event from the core |
| evt_sw0 | input | 1 | Software event 0 |
| evt_sw1 | input | 1 | Software event 1 |
| evt_xerr | input | 1 | External error event |
| xerr_code | input | CODE_W | Error code captured with an external error |
| host_irq | output | 1 | Routed host interrupt |

## Verification
The assertions assume that at most one register word is written per cycle, because the bus carries a single address. They also assume that event inputs are synchronous to `clk` and stable around its rising edge. The bench drives every bus field and event only at the falling edge, issues one write at a time, and holds event pulses for a full cycle. Same-cycle event-and-clear collisions are produced on purpose, since the sticky and clear properties are written to allow for them.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;

    localparam int NSRC   = 4;
    localparam int ADDR_W = 4;

    localparam int SRC_HALT = 0;
    localparam int SRC_SW0  = 1;
    localparam int SRC_SW1  = 2;
    localparam int SRC_XERR = 3;

    typedef logic [NSRC-1:0] src_vec_t;

    typedef enum logic [ADDR_W-1:0] {
        RG_STAT = 4'd0,
        RG_SET  = 4'd1,
        RG_CLR  = 4'd2,
        RG_MASK = 4'd3,
        RG_MSET = 4'd4,
        RG_MCLR = 4'd5,
        RG_DEST = 4'd6,
        RG_DSET = 4'd7,
        RG_DCLR = 4'd8,
        RG_XERR = 4'd9
    } reg_sel_e;

    typedef struct packed {
        src_vec_t stat;
    } stat_st_t;

    typedef struct packed {
        src_vec_t val;
    } gate_st_t;

    typedef struct packed {
        logic irq;
    } top_st_t;

endpackage

// File: rtl/irq_status_bank.sv
module irq_status_bank
    import irq_agg_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  src_vec_t evt,
    input  logic     set_stb,
    input  logic     clr_stb,
    input  src_vec_t wval,
    output src_vec_t stat_d,
    output src_vec_t stat_q
);

    stat_st_t st_d, st_q;

    always_comb begin
        src_vec_t clr_bits;
        src_vec_t set_bits;
        clr_bits  = clr_stb ? wval : '0;
        set_bits  = set_stb ? wval : '0;
        // events are ORed in after the clear so they win a collision
        st_d.stat = (st_q.stat & ~clr_bits) | set_bits | evt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign stat_d = st_d.stat;
    assign stat_q = st_q.stat;

endmodule

// File: rtl/irq_gate_reg.sv
module irq_gate_reg
    import irq_agg_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     wr_stb,
    input  logic     set_stb,
    input  logic     clr_stb,
    input  src_vec_t wval,
    output src_vec_t val_d,
    output src_vec_t val_q
);

    gate_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_stb)  st_d.val = wval;
        if (set_stb) st_d.val = st_q.val | wval;
        if (clr_stb) st_d.val = st_q.val & ~wval;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign val_d = st_d.val;
    assign val_q = st_q.val;

endmodule

// File: rtl/irq_xerr_log.sv
module irq_xerr_log #(
    parameter int CODE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              evt,
    input  logic [CODE_W-1:0] code_in,
    input  logic              wr_stb,
    input  logic              keep_valid,
    output logic              valid_q,
    output logic [CODE_W-1:0] code_q
);

    typedef struct packed {
        logic              valid;
        logic [CODE_W-1:0] code;
    } xlog_st_t;

    xlog_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (evt) begin
            st_d.valid = 1'b1;
            st_d.code  = code_in;
        end else if (wr_stb) begin
            st_d.valid = st_q.valid & keep_valid;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign valid_q = st_q.valid;
    assign code_q  = st_q.code;

endmodule

// File: rtl/irq_agg_unit.sv
module irq_agg_unit
    import irq_agg_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int CODE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              evt_halt,
    input  logic              evt_sw0,
    input  logic              evt_sw1,
    input  logic              evt_xerr,
    input  logic [CODE_W-1:0] xerr_code,
    output logic              host_irq
);

    localparam int VALID_POS = DATA_W - 1;
    localparam int NGATE     = 2;
    localparam int G_MASK    = 0;
    localparam int G_DEST    = 1;

    src_vec_t evt_v;
    src_vec_t wval;
    reg_sel_e sel;

    assign evt_v[SRC_HALT] = evt_halt;
    assign evt_v[SRC_SW0]  = evt_sw0;
    assign evt_v[SRC_SW1]  = evt_sw1;
    assign evt_v[SRC_XERR] = evt_xerr;
    assign wval            = bus_wdata[NSRC-1:0];
    assign sel             = reg_sel_e'(bus_addr);

    // write decode
    logic             st_set, st_clr, x_wr;
    logic [NGATE-1:0] g_wr, g_set, g_clr;

    always_comb begin
        st_set = 1'b0;
        st_clr = 1'b0;
        x_wr   = 1'b0;
        g_wr   = '0;
        g_set  = '0;
        g_clr  = '0;
        if (bus_wr) begin
            case (sel)
                RG_SET:  st_set        = 1'b1;
                RG_CLR:  st_clr        = 1'b1;
                RG_MASK: g_wr[G_MASK]  = 1'b1;
                RG_MSET: g_set[G_MASK] = 1'b1;
                RG_MCLR: g_clr[G_MASK] = 1'b1;
                RG_DEST: g_wr[G_DEST]  = 1'b1;
                RG_DSET: g_set[G_DEST] = 1'b1;
                RG_DCLR: g_clr[G_DEST] = 1'b1;
                RG_XERR: x_wr          = 1'b1;
                default: ;
            endcase
        end
    end

    src_vec_t stat_d, stat_q;

    irq_status_bank u_stat (
        .clk     (clk),
        .rst_n   (rst_n),
        .evt     (evt_v),
        .set_stb (st_set),
        .clr_stb (st_clr),
        .wval    (wval),
        .stat_d  (stat_d),
        .stat_q  (stat_q)
    );

    src_vec_t gate_d [NGATE];
    src_vec_t gate_q [NGATE];

    for (genvar k = 0; k < NGATE; k++) begin : g_gate
        irq_gate_reg u_gate (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_stb  (g_wr[k]),
            .set_stb (g_set[k]),
            .clr_stb (g_clr[k]),
            .wval    (wval),
            .val_d   (gate_d[k]),
            .val_q   (gate_q[k])
        );
    end

    logic              xv_q;
    logic [CODE_W-1:0] xc_q;

    irq_xerr_log #(.CODE_W(CODE_W)) u_xlog (
        .clk        (clk),
        .rst_n      (rst_n),
        .evt        (evt_xerr),
        .code_in    (xerr_code),
        .wr_stb     (x_wr),
        .keep_valid (bus_wdata[VALID_POS]),
        .valid_q    (xv_q),
        .code_q     (xc_q)
    );

    // routed interrupt flop, fed from next-state values
    top_st_t top_d, top_q;

    always_comb begin
        top_d.irq = |(stat_d & gate_d[G_MASK] & gate_d[G_DEST]);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) top_q <= '0;
        else        top_q <= top_d;
    end

    assign host_irq = top_q.irq;

    // read mux
    always_comb begin
        bus_rdata = '0;
        case (sel)
            RG_STAT, RG_SET, RG_CLR:    bus_rdata[NSRC-1:0] = stat_q;
            RG_MASK, RG_MSET, RG_MCLR:  bus_rdata[NSRC-1:0] = gate_q[G_MASK];
            RG_DEST, RG_DSET, RG_DCLR:  bus_rdata[NSRC-1:0] = gate_q[G_DEST];
            RG_XERR: begin
                bus_rdata[VALID_POS]  = xv_q;
                bus_rdata[CODE_W-1:0] = xc_q;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/irq_agg_chk.sv
module irq_agg_chk
    import irq_agg_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic              evt_halt,
    input logic              evt_sw0,
    input logic              evt_sw1,
    input logic              evt_xerr,
    input src_vec_t          stat,
    input src_vec_t          mask,
    input src_vec_t          dest,
    input logic              xvalid,
    input logic              irq
);

    src_vec_t evt_v;
    src_vec_t clr_m;
    src_vec_t mset_m;

    assign evt_v  = {evt_xerr, evt_sw1, evt_sw0, evt_halt};
    assign clr_m  = (bus_wr && bus_addr == RG_CLR)  ? bus_wdata[NSRC-1:0] : '0;
    assign mset_m = (bus_wr && bus_addr == RG_MSET) ? bus_wdata[NSRC-1:0] : '0;

    p_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_m & ~evt_v) != '0 |=> (stat & $past(clr_m & ~evt_v)) == '0);

    p_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ($past(stat) & ~$past(clr_m) & ~stat) == '0);

    p_event_r1: assert property (@(posedge clk) disable iff (!rst_n)
        evt_v != '0 |=> (stat & $past(evt_v)) == $past(evt_v));

    p_route_r5: assert property (@(posedge clk) disable iff (!rst_n)
        irq == |(stat & mask & dest));

    p_mset_r6: assert property (@(posedge clk) disable iff (!rst_n)
        mset_m != '0 |=> (mask & $past(mset_m)) == $past(mset_m));

    p_xvalid_r8: assert property (@(posedge clk) disable iff (!rst_n)
        evt_xerr |=> xvalid);

endmodule

bind irq_agg_unit irq_agg_chk #(.DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .evt_halt  (evt_halt),
    .evt_sw0   (evt_sw0),
    .evt_sw1   (evt_sw1),
    .evt_xerr  (evt_xerr),
    .stat      (stat_q),
    .mask      (gate_q[0]),
    .dest      (gate_q[1]),
    .xvalid    (xv_q),
    .irq       (host_irq)
);

// File: tb/sim_irq_agg_unit.sv
module sim_irq_agg_unit;

    localparam int CLK_PERIOD = 10;
    localparam int DW = 32;
    localparam int CW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_wr = 1'b0;
    logic [3:0]    bus_addr = '0;
    logic [DW-1:0] bus_wdata = '0;
    logic [DW-1:0] bus_rdata;
    logic          evt_halt = 1'b0, evt_sw0 = 1'b0, evt_sw1 = 1'b0, evt_xerr = 1'b0;
    logic [CW-1:0] xerr_code = '0;
    logic          host_irq;

    int n_cmp = 0;
    int n_bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    irq_agg_unit #(.DATA_W(DW), .CODE_W(CW)) u0 (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .evt_halt(evt_halt),
        .evt_sw0(evt_sw0), .evt_sw1(evt_sw1), .evt_xerr(evt_xerr),
        .xerr_code(xerr_code), .host_irq(host_irq)
    );

    task automatic chk(input string req, input logic [DW-1:0] got, input logic [DW-1:0] exp);
        n_cmp++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got 0x%08h expected 0x%08h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [DW-1:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0; bus_wdata = '0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [DW-1:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic done();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_bad++;
        $display("FAIL watchdog expired");
        done();
    end

    initial begin
        logic [DW-1:0] r;
        repeat (3) @(negedge clk);
        // R9: reset values
        for (int a = 0; a < 10; a++) begin
            rd(4'(a), r);
            chk("R9 reset read", r, '0);
        end
        chk("R9 reset irq", {31'd0, host_irq}, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R3, R5, R6, R7: exhaustive sweep of status x mask x dest
        for (int s = 0; s < 16; s++) begin
            wr(4'd2, 32'hF);
            wr(4'd1, 32'(s));
            rd(4'd0, r);
            chk("R3 set alias", r, 32'(s));
            for (int m = 0; m < 16; m++) begin
                if (m % 2 == 1) wr(4'd3, 32'(m));
                else begin
                    wr(4'd5, 32'hF);
                    wr(4'd4, 32'(m));
                end
                rd(4'd3, r);
                chk("R6 mask value", r, 32'(m));
                for (int d = 0; d < 16; d++) begin
                    if (d % 3 == 0) wr(4'd6, 32'(d));
                    else if (d % 3 == 1) begin
                        wr(4'd8, 32'hF);
                        wr(4'd7, 32'(d));
                    end else begin
                        wr(4'd6, 32'h0);
                        wr(4'd7, 32'(d));
                    end
                    rd(4'd6, r);
                    chk("R7 dest value", r, 32'(d));
                    chk("R5 routed irq", {31'd0, host_irq}, {31'd0, |(s & m & d)});
                end
            end
        end

        // R2: partial clear
        wr(4'd1, 32'hF);
        wr(4'd2, 32'h5);
        rd(4'd2, r);
        chk("R2 partial clear", r, 32'hA);

        // R3: status word ignores writes
        wr(4'd0, 32'hF);
        rd(4'd0, r);
        chk("R3 status write ignored", r, 32'hA);

        // R6 / R7 partial clear aliases
        wr(4'd3, 32'hF);
        wr(4'd5, 32'h6);
        rd(4'd4, r);
        chk("R6 mask clear alias", r, 32'h9);
        wr(4'd6, 32'hF);
        wr(4'd8, 32'h3);
        rd(4'd7, r);
        chk("R7 dest clear alias", r, 32'hC);

        // R1 / R4: event sets its bit and it stays set
        wr(4'd2, 32'hF);
        @(negedge clk); evt_sw1 = 1'b1;
        @(negedge clk); evt_sw1 = 1'b0;
        @(negedge clk);
        rd(4'd0, r);
        chk("R1 sw1 event sticky at bit 2 (R4)", r, 32'h4);
        @(negedge clk); evt_sw0 = 1'b1;
        @(negedge clk); evt_sw0 = 1'b0;
        rd(4'd0, r);
        chk("R1 sw0 event at bit 1", r, 32'h6);

        // R4: event beats clear in the same cycle
        @(negedge clk);
        evt_halt = 1'b1; bus_wr = 1'b1; bus_addr = 4'd2; bus_wdata = 32'h7;
        @(negedge clk);
        evt_halt = 1'b0; bus_wr = 1'b0; bus_wdata = '0;
        rd(4'd0, r);
        chk("R4 event wins over clear", r, 32'h1);

        // R5: latency of the routed line
        wr(4'd3, 32'h0);
        wr(4'd6, 32'h1);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = 4'd3; bus_wdata = 32'h1;
        #1;
        chk("R5 irq before write edge", {31'd0, host_irq}, 0);
        @(negedge clk);
        bus_wr = 1'b0;
        chk("R5 irq after write edge", {31'd0, host_irq}, 1);

        // R8: error log
        wr(4'd2, 32'hF);
        @(negedge clk); evt_xerr = 1'b1; xerr_code = 8'h5A;
        @(negedge clk); evt_xerr = 1'b0; xerr_code = 8'h00;
        rd(4'd9, r);
        chk("R8 log valid and code", r, 32'h8000_005A);
        rd(4'd0, r);
        chk("R1 xerr at bit 3", r, 32'h8);
        wr(4'd9, 32'h8000_00FF);
        rd(4'd9, r);
        chk("R8 valid kept, code unchanged", r, 32'h8000_005A);
        wr(4'd9, 32'h0000_0000);
        rd(4'd9, r);
        chk("R8 valid cleared", r, 32'h0000_005A);
        rd(4'd0, r);
        chk("R8 status independent of log", r, 32'h8);

        // R10: unmapped words
        for (int a = 10; a < 16; a++) begin
            wr(4'(a), 32'hFFFF_FFFF);
            rd(4'(a), r);
            chk("R10 unmapped reads zero", r, '0);
        end
        rd(4'd0, r);
        chk("R10 status untouched", r, 32'h8);
        rd(4'd3, r);
        chk("R10 mask untouched", r, 32'h1);
        rd(4'd6, r);
        chk("R10 dest untouched", r, 32'h1);

        done();
    end

endmodule